// File: doc/BRIEF.md
# Erase-Block Write-Protection Range Controller

This block holds a write-protection state for each of a parameterised number of erase blocks in a flash array. Each block is unlocked, locked, or lock-tight. Software loads a first-block and a last-block bound and then issues a lock-family command. The controller then visits the blocks in that range, one per clock, and changes their protection state. It records the state most recently written in a protection-status register. When the walk ends it pulses a completion strobe, which is also the interrupt flag, together with an error strobe.

Erase and program engines use a combinational query port to read the state of any block before they act on it. This block reports protection state only and does not gate array writes itself. Once a block is lock-tight, only a reset can return it to another state.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset every block reads locked (3'b010), `wp_status` reads 3'b010, both bounds read 0, and `busy`, `done` and `cmd_err` are low. State encodings are one-hot: lock-tight 3'b001, locked 3'b010, unlocked 3'b100.
- R2: A pulse on `reg_wr_start` stores `reg_wdata & (NUM_BLKS-1)` into both the first and the last bound. A pulse on `reg_wr_end` stores the masked value into the last bound only.
- R3: Code 8'h23 unlocks every block from the first bound to the last bound inclusive. The walk handles one block per clock, in ascending order.
- R4: Code 8'h27 unlocks blocks 0 to NUM_BLKS-1 and does not use either bound register.
- R5: Code 8'h2a locks every block from the first bound to the last bound inclusive.
- R6: During an unlock or lock walk, the first lock-tight block reached ends the walk, and neither that block nor any later block changes. A lock-tight block stays lock-tight until reset.
- R7: Code 8'h2c makes every block in the range lock-tight, except blocks that are currently unlocked. The walk skips those blocks, leaves them unchanged, and continues past them.
- R8: Each block that the walk writes places its new state into `wp_status`. Blocks that are skipped or not reached leave `wp_status` unchanged.
- R9: An accepted command raises `busy` on the next clock. `done` is a one-cycle pulse, issued exactly once per accepted command, in the cycle in which `busy` first reads low. If the first bound is greater than the last bound, the walk writes no block and `done` arrives one clock after `busy` rises.
- R10: While `busy` is high, `cmd_valid` is ignored. Any code outside {23,27,2a,2c} hex is ignored. An ignored command changes no block state and produces no `done`.
- R11: `cmd_err` pulses with `done` only when the walk index reaches NUM_BLKS. Because both bounds are masked, this never happens, and `cmd_err` stays low for every command.
- R12: A command that is accepted in the same cycle as a bound write uses the bound values from before that write. Bound writes that occur during a walk do not change the walk in progress.
- R13: `query_state` gives the current state of block `query_blk` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| reg_wr_start | input | 1 | Write strobe for the first-block bound, which also sets the last bound |
| reg_wr_end | input | 1 | Write strobe for the last-block bound |
| reg_wdata | input | DATA_W | Bound write data, masked by NUM_BLKS-1 |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| start_blk | output | IDX_W | Current first-block bound |
| end_blk | output | IDX_W | Current last-block bound |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle completion pulse, which is the interrupt flag |
| cmd_err | output | 1 | Range error, pulsed together with done |
| wp_status | output | 3 | Protection state most recently written |
| query_blk | input | IDX_W | Block index for the query port |
| query_state | output | 3 | One-hot state of the queried block |

## Verification
Two things can fall in the same cycle: a command being accepted and a bound register being written. A bound write can also arrive at any point while a walk is running. The bench drives `reg_wr_start` in the same cycle as a lock command. It then writes a new first bound while that walk is still active. In both cases the walk must cover the range that existed before the write, while the bound outputs show the new value on the next clock. A behavioural model captures the range when the command is accepted and applies register writes only after that. Its per-clock comparison of every block state, `wp_status`, `busy` and `done` decides whether the walk picked up the new value.

// File: rtl/blk_lock_pkg.sv
`timescale 1ns/1ps
package blk_lock_pkg;

  // One-hot protection states; the encodings are observable at the ports.
  typedef enum logic [2:0] {
    BS_TIGHT    = 3'b001,
    BS_LOCKED   = 3'b010,
    BS_UNLOCKED = 3'b100
  } blk_state_e;

  typedef enum logic [1:0] {
    OP_UNLOCK = 2'd0,
    OP_LOCK   = 2'd1,
    OP_TIGHT  = 2'd2
  } walk_op_e;

  localparam logic [7:0] CODE_UNLOCK_RANGE = 8'h23;
  localparam logic [7:0] CODE_UNLOCK_ALL   = 8'h27;
  localparam logic [7:0] CODE_LOCK_RANGE   = 8'h2a;
  localparam logic [7:0] CODE_TIGHT_RANGE  = 8'h2c;

endpackage

// File: rtl/blk_lock_bounds.sv
`timescale 1ns/1ps
module blk_lock_bounds #(
  parameter int NUM_BLKS = 16,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_first,
  input  logic              wr_last,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  first_q,
  output logic [IDX_W-1:0]  last_q
);

  localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(NUM_BLKS - 1);

  logic [IDX_W-1:0] masked;
  logic [IDX_W-1:0] first_n;
  logic [IDX_W-1:0] last_n;
  logic             bound_en;
  logic             unused_hi;

  assign masked    = wdata[IDX_W-1:0] & IDX_MASK;
  assign unused_hi = ^wdata[DATA_W-1:IDX_W];
  assign bound_en  = wr_first | wr_last;

  always_comb begin
    first_n = first_q;
    last_n  = last_q;
    if (wr_first) begin
      first_n = masked;
      last_n  = masked;
    end
    if (wr_last) begin
      last_n = masked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (bound_en) begin
      first_q <= first_n;
      last_q  <= last_n;
    end
  end

  AST_FIRST_SETS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_first |=> (first_q == last_q)); // R2

  AST_BOUNDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_first && !wr_last |=> $stable(first_q) && $stable(last_q)); // R2

endmodule

// File: rtl/blk_lock_store.sv
`timescale 1ns/1ps
module blk_lock_store
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLKS = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_state,
  input  logic [IDX_W-1:0] walk_idx,
  output logic [2:0]       walk_state,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [2:0]       qry_state
);

  localparam int SLOTS = 1 << IDX_W;

  logic [2:0] state_q [NUM_BLKS];
  logic [2:0] padded  [SLOTS];

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    if (gi < NUM_BLKS) begin : g_real
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          state_q[gi] <= BS_LOCKED;
        end else if (hit) begin
          state_q[gi] <= wr_state;
        end
      end

      assign padded[gi] = state_q[gi];

      AST_TIGHT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q[gi] == BS_TIGHT) |=> (state_q[gi] == BS_TIGHT)); // R6

      AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q[gi]) == 1); // R1
    end else begin : g_pad
      assign padded[gi] = BS_LOCKED;
    end
  end

  assign walk_state = padded[walk_idx];
  assign qry_state  = padded[qry_idx];

  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_state) == 1)); // R8

endmodule

// File: rtl/blk_lock_walker.sv
`timescale 1ns/1ps
module blk_lock_walker
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLKS = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [2:0]       rd_state,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [2:0]       wr_state,
  output logic             busy,
  output logic             done,
  output logic             range_err,
  output logic [2:0]       wp_status
);

  localparam int CUR_W = IDX_W + 1;
  localparam logic [CUR_W-1:0] LAST_BLK  = CUR_W'(NUM_BLKS - 1);
  localparam logic [CUR_W-1:0] BLK_LIMIT = CUR_W'(NUM_BLKS);

  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             err_q,  err_n;
  walk_op_e         op_q,   op_n;
  logic [CUR_W-1:0] cur_q,  cur_n;
  logic [CUR_W-1:0] end_q,  end_n;
  logic [2:0]       wp_q,   wp_n;

  logic             code_hit;
  logic             code_all;
  walk_op_e         code_op;
  logic             accept;
  logic             finish;
  logic             walk_en;

  // Command decode
  always_comb begin
    code_hit = 1'b1;
    code_all = 1'b0;
    code_op  = OP_UNLOCK;
    unique case (cmd_code)
      CODE_UNLOCK_RANGE: code_op = OP_UNLOCK;
      CODE_UNLOCK_ALL: begin
        code_op  = OP_UNLOCK;
        code_all = 1'b1;
      end
      CODE_LOCK_RANGE:   code_op = OP_LOCK;
      CODE_TIGHT_RANGE:  code_op = OP_TIGHT;
      default:           code_hit = 1'b0;
    endcase
  end

  assign accept  = !busy_q && cmd_valid && code_hit;
  assign walk_en = busy_q || accept;

  // Next-state logic
  always_comb begin
    busy_n   = busy_q;
    op_n     = op_q;
    cur_n    = cur_q;
    end_n    = end_q;
    wp_n     = wp_q;
    err_n    = 1'b0;
    finish   = 1'b0;
    wr_en    = 1'b0;
    wr_state = BS_LOCKED;
    if (!busy_q) begin
      if (accept) begin
        busy_n = 1'b1;
        op_n   = code_op;
        cur_n  = code_all ? '0 : {1'b0, first_idx};
        end_n  = code_all ? LAST_BLK : {1'b0, last_idx};
      end
    end else if (cur_q > end_q) begin
      finish = 1'b1;
    end else if (cur_q >= BLK_LIMIT) begin
      finish = 1'b1;
      err_n  = 1'b1;
    end else begin
      if (op_q == OP_TIGHT) begin
        if (rd_state != BS_UNLOCKED) begin
          wr_en    = 1'b1;
          wr_state = BS_TIGHT;
        end
        cur_n = cur_q + CUR_W'(1);
      end else if (rd_state == BS_TIGHT) begin
        finish = 1'b1;
      end else begin
        wr_en    = 1'b1;
        wr_state = (op_q == OP_LOCK) ? BS_LOCKED : BS_UNLOCKED;
        cur_n    = cur_q + CUR_W'(1);
      end
    end
    if (finish) begin
      busy_n = 1'b0;
    end
    if (wr_en) begin
      wp_n = wr_state;
    end
    done_n = finish;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wp_q   <= BS_LOCKED;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      err_q  <= err_n;
      wp_q   <= wp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_UNLOCK;
      cur_q <= '0;
      end_q <= '0;
    end else if (walk_en) begin
      op_q  <= op_n;
      cur_q <= cur_n;
      end_q <= end_n;
    end
  end

  assign rd_idx    = cur_q[IDX_W-1:0];
  assign wr_idx    = cur_q[IDX_W-1:0];
  assign busy      = busy_q;
  assign done      = done_q;
  assign range_err = err_q;
  assign wp_status = wp_q;

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy_q); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))); // R9

  AST_WP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wp_q == $past(wr_state))); // R8

  AST_CURSOR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cur_q <= end_q)) |-> (cur_q < BLK_LIMIT)); // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q); // R11

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> (busy_q && $stable(op_q))); // R10

endmodule

// File: rtl/blk_lock_ctrl.sv
`timescale 1ns/1ps
module blk_lock_ctrl #(
  parameter int NUM_BLKS = 16,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = $clog2(NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_start,
  input  logic              reg_wr_end,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic [IDX_W-1:0]  start_blk,
  output logic [IDX_W-1:0]  end_blk,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic [2:0]        wp_status,
  input  logic [IDX_W-1:0]  query_blk,
  output logic [2:0]        query_state
);

  logic [IDX_W-1:0] walk_idx;
  logic [2:0]       walk_state;
  logic             st_wr_en;
  logic [IDX_W-1:0] st_wr_idx;
  logic [2:0]       st_wr_state;

  blk_lock_bounds #(
    .NUM_BLKS (NUM_BLKS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) i_bounds (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_first (reg_wr_start),
    .wr_last  (reg_wr_end),
    .wdata    (reg_wdata),
    .first_q  (start_blk),
    .last_q   (end_blk)
  );

  blk_lock_store #(
    .NUM_BLKS (NUM_BLKS),
    .IDX_W    (IDX_W)
  ) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (st_wr_en),
    .wr_idx     (st_wr_idx),
    .wr_state   (st_wr_state),
    .walk_idx   (walk_idx),
    .walk_state (walk_state),
    .qry_idx    (query_blk),
    .qry_state  (query_state)
  );

  blk_lock_walker #(
    .NUM_BLKS (NUM_BLKS),
    .IDX_W    (IDX_W)
  ) i_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .first_idx (start_blk),
    .last_idx  (end_blk),
    .rd_state  (walk_state),
    .rd_idx    (walk_idx),
    .wr_en     (st_wr_en),
    .wr_idx    (st_wr_idx),
    .wr_state  (st_wr_state),
    .busy      (busy),
    .done      (done),
    .range_err (cmd_err),
    .wp_status (wp_status)
  );

  AST_WP_MATCHES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> (wp_status == $past(st_wr_state))); // R8

endmodule

// File: tb/test_blk_lock_ctrl.sv
`timescale 1ns/1ps
module test_blk_lock_ctrl;

  localparam int NB = 16;
  localparam int DW = 16;
  localparam int IW = 4;

  logic          clk;
  logic          rst_n;
  logic          reg_wr_start;
  logic          reg_wr_end;
  logic [DW-1:0] reg_wdata;
  logic          cmd_valid;
  logic [7:0]    cmd_code;
  logic [IW-1:0] start_blk;
  logic [IW-1:0] end_blk;
  logic          busy;
  logic          done;
  logic          cmd_err;
  logic [2:0]    wp_status;
  logic [IW-1:0] query_blk;
  logic [2:0]    query_state;

  blk_lock_ctrl #(.NUM_BLKS(NB), .DATA_W(DW), .IDX_W(IW)) i_blk_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_start(reg_wr_start), .reg_wr_end(reg_wr_end),
    .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .start_blk(start_blk), .end_blk(end_blk), .busy(busy), .done(done),
    .cmd_err(cmd_err), .wp_status(wp_status), .query_blk(query_blk),
    .query_state(query_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    vectors = 0;
  int    fails   = 0;
  string phase   = "R1";

  // Behavioural reference model
  int m_st [NB];
  int m_start, m_end, m_wp;
  int m_busy, m_done, m_err;
  int m_cur, m_last, m_op; // op: 0 unlock, 1 lock, 2 tight

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) m_st[b] = 2;
      m_start = 0; m_end = 0; m_wp = 2;
      m_busy = 0; m_done = 0; m_err = 0;
      m_cur = 0; m_last = 0; m_op = 0;
    end else begin
      int fin;
      int ef;
      fin = 0; ef = 0;
      if (m_busy != 0) begin
        if (m_cur > m_last) fin = 1;
        else if (m_cur >= NB) begin fin = 1; ef = 1; end
        else if (m_op == 2) begin
          if (m_st[m_cur] != 4) begin m_st[m_cur] = 1; m_wp = 1; end
          m_cur++;
        end else if (m_st[m_cur] == 1) fin = 1;
        else begin
          m_st[m_cur] = (m_op == 1) ? 2 : 4;
          m_wp = m_st[m_cur];
          m_cur++;
        end
        if (fin != 0) m_busy = 0;
      end else if (cmd_valid) begin
        if (cmd_code == 8'h23 || cmd_code == 8'h27 || cmd_code == 8'h2a || cmd_code == 8'h2c) begin
          m_busy = 1;
          m_op   = (cmd_code == 8'h2a) ? 1 : (cmd_code == 8'h2c) ? 2 : 0;
          m_cur  = (cmd_code == 8'h27) ? 0 : m_start;
          m_last = (cmd_code == 8'h27) ? NB - 1 : m_end;
        end
      end
      m_done = fin; m_err = ef;
      if (reg_wr_start) begin
        m_start = int'(reg_wdata) % NB;
        m_end   = m_start;
      end
      if (reg_wr_end) m_end = int'(reg_wdata) % NB;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R9", "busy", int'(busy), m_busy);
    cmp("R9", "done", int'(done), m_done);
    cmp("R11", "cmd_err", int'(cmd_err), m_err);
    cmp("R8", "wp_status", int'(wp_status), m_wp);
    cmp("R2", "start_blk", int'(start_blk), m_start);
    cmp("R2", "end_blk", int'(end_blk), m_end);
    for (int b = 0; b < NB; b++) begin
      query_blk = IW'(b);
      #0.5;
      cmp({"R13 ", phase}, $sformatf("state of block %0d", b), int'(query_state), m_st[b]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_start(int v);
    reg_wr_start = 1'b1; reg_wdata = DW'(v);
    tick();
    reg_wr_start = 1'b0;
  endtask

  task automatic set_end(int v);
    reg_wr_end = 1'b1; reg_wdata = DW'(v);
    tick();
    reg_wr_end = 1'b0;
  endtask

  task automatic issue(logic [7:0] code);
    cmd_valid = 1'b1; cmd_code = code;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40 && m_busy != 0; k++) tick();
    tick();
  endtask

  task automatic run_range(int s, int e, logic [7:0] code);
    set_start(s);
    set_end(e);
    issue(code);
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_start = 1'b0; reg_wr_end = 1'b0; reg_wdata = '0;
    cmd_valid = 1'b0; cmd_code = '0; query_blk = '0;
    repeat (3) @(negedge clk);
    fork
      begin
        phase = "R1";
        check_all();
        rst_n = 1'b1;
        tick();

        phase = "R2";
        set_start(16'h0013);   // masked to 3, copied into end
        set_end(16'hff27);     // masked to 7

        phase = "R4";
        set_start(5);
        issue(8'h27);          // whole array regardless of bounds
        wait_idle();

        phase = "R5";
        run_range(0, 15, 8'h2a);

        phase = "R3";
        run_range(3, 7, 8'h23);

        phase = "R7";
        run_range(5, 6, 8'h2c); // both unlocked: skipped
        run_range(2, 9, 8'h2c); // 2,8,9 tight; 3..7 skipped

        phase = "R5";
        run_range(10, 12, 8'h2a);

        phase = "R6";
        run_range(0, 15, 8'h2a); // stops at block 2
        run_range(4, 15, 8'h23); // stops at block 8
        run_range(10, 15, 8'h23);
        issue(8'h27);            // stops at block 2
        wait_idle();

        phase = "R9";
        set_start(12);
        set_end(4);
        issue(8'h23);            // empty range
        wait_idle();

        phase = "R10";
        issue(8'h55);
        tick(); tick();
        set_start(10);
        set_end(15);
        issue(8'h2a);
        cmd_valid = 1'b1; cmd_code = 8'h23;
        repeat (4) tick();
        cmd_valid = 1'b0;
        wait_idle();

        phase = "R12";
        set_start(10);
        set_end(11);
        reg_wr_start = 1'b1; reg_wdata = 16'd0;
        cmd_valid = 1'b1; cmd_code = 8'h23;
        tick();
        reg_wr_start = 1'b0; cmd_valid = 1'b0;
        set_start(14);           // during walk
        wait_idle();

        phase = "R11";
        run_range(15, 15, 8'h2c);
        run_range(15, 15, 8'h23);
        run_range(13, 15, 8'h2a);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (phase %s) actual=timeout expected=finish", phase);
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule